// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers level-sensitive interrupt lines from peripherals and turns them into one interrupt request for a processor. It has two banks of 32 peripheral lines, numbered 0 to 31 and 32 to 63. A small group of basic sources sits beside them, and basic source 0 is a timer. Every line has an enable bit. Software never writes an enable mask directly. It writes a word to a set register, where each 1 turns a line on, or to a clear register, where each 1 turns a line off. A zero bit in either word leaves its line as it is. Because of this, two drivers can share a bank without a read-modify-write race.

A status word for the basic sources gives the raw level of each basic source. It also carries one summary bit per bank, which shows that the bank has at least one line that is both asserted and enabled. Software can read the status word first and then read the bank it points to. An encoded request index gives the winning source without any scan. The timer wins over everything. After the timer, the lowest enabled, asserted bank line wins. The other basic sources come last.

The register port is a plain 32-bit bus. A write is a single cycle with select and write-enable high. Read data is combinational from the address.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit is zero, and `irq_out` and `req_valid` are low whatever the input lines do.
- R2: A write to a set register turns on each line whose data bit is 1 and leaves every other line unchanged. The set registers are at 0x10 (bank 0, lines 0–31), 0x14 (bank 1, lines 32–63) and 0x18 (basic sources, data bits 7:0).
- R3: A write to a clear register turns off each line whose data bit is 1 and leaves every other line unchanged. The clear registers are at 0x1C (bank 0), 0x20 (bank 1) and 0x24 (basic sources, data bits 7:0).
- R4: A read of a set or clear register returns the current enable mask of its group. For the basic group the mask is in bits 7:0 and bits 31:8 read as zero.
- R5: A read at 0x04 or 0x08 returns the live input levels of bank 0 or bank 1. A write to either address changes no enable.
- R6: A read at 0x00 returns the basic source levels in bits 7:0, with the timer in bit 0. Bit 8 is 1 when bank 0 has a line that is asserted and enabled. Bit 9 is the same for bank 1. All other bits read as zero.
- R7: `irq_out` is high exactly when some line, basic or bank, is both asserted and enabled. It follows the inputs in the same cycle.
- R8: `req_valid` equals `irq_out`. `req_index` follows this priority:
  - It is 0 when the timer is asserted and enabled.
  - Otherwise it is 64+n, where n is the lowest-numbered bank line (0–63) that is asserted and enabled.
  - Otherwise it is k, where k is the lowest basic source that is asserted and enabled.
- R9: A read of any other address returns zero, and a write to one changes no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe, used with `bus_sel` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| basic_irq | input | 8 | Basic source levels, with the timer in bit 0 |
| bank_irq | input | 64 | Peripheral line levels, line n at bit n |
| irq_out | output | 1 | Combined interrupt request |
| req_valid | output | 1 | Encoded request is valid |
| req_index | output | 7 | Encoded index of the winning source |

## Verification
Some behaviours are checked on every cycle. The set and clear writes must move only the enable bits whose data bits are 1. A write to a pending or unmapped address must leave every enable unchanged. The valid flag must track the combined output. Asserted and enabled timer must always give index zero. Other behaviours need the bench's scenarios to show them. These are the full priority order when bank lines and non-timer basic sources contend, the 64+n index coding at both ends of the line range, and the composition of the read data for every register.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   // Byte offsets that software decodes
   localparam logic [7:0] OFS_BASIC_STAT = 8'h00;
   localparam logic [7:0] OFS_LVL_BASE   = 8'h04; // + 4*bank
   localparam logic [7:0] OFS_SET_BASE   = 8'h10; // + 4*bank
   localparam logic [7:0] OFS_BASIC_SET  = 8'h18;
   localparam logic [7:0] OFS_CLR_BASE   = 8'h1C; // + 4*bank
   localparam logic [7:0] OFS_BASIC_CLR  = 8'h24;
   localparam int unsigned SUMMARY_LSB   = 8;     // bit of bank 0 summary

   function automatic logic [7:0] bank_ofs(logic [7:0] base, int unsigned b);
      return base + 8'(4 * b);
   endfunction
endpackage

// File: rtl/irq_en_group.sv
// Enable mask of one group, changed only through set / clear strobes
module irq_en_group #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wbits,
   output logic [W-1:0] en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= '0;
      end else if (set_we) begin
         en <= en | wbits;
      end else if (clr_we) begin
         en <= en & ~wbits;
      end
   end
endmodule

// File: rtl/irq_first_set.sv
// Lowest-index set bit finder
module irq_first_set #(
   parameter int unsigned W  = 64,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign found = |vec;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned BASIC_W   = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned LINES    = NUM_BANKS * BANK_W,
   localparam int unsigned IDX_W    = $clog2(LINES) + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [BASIC_W-1:0]           basic_irq,
   input  logic [LINES-1:0]             bank_irq,
   output logic                         irq_out,
   output logic                         req_valid,
   output logic [IDX_W-1:0]             req_index
);
   localparam int unsigned BANK_IW  = $clog2(LINES);
   localparam int unsigned BASIC_IW = (BASIC_W > 1) ? $clog2(BASIC_W) : 1;

   // Elaboration checks
   if (NUM_BANKS != 2) begin : g_bad_banks
      $error("irq_bank_ctrl: register map holds exactly two banks");
   end
   if (BANK_W > DATA_W || BASIC_W > SUMMARY_LSB) begin : g_bad_width
      $error("irq_bank_ctrl: group width exceeds its register field");
   end
   if (SUMMARY_LSB + NUM_BANKS > DATA_W || ADDR_W < 6 || ADDR_W > 8) begin : g_bad_bus
      $error("irq_bank_ctrl: bus geometry does not fit the register map");
   end
   if ((LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("irq_bank_ctrl: line count must be a power of two");
   end

   logic wr_stb;
   assign wr_stb = bus_sel & bus_wr;

   function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // ---------------- enable state ----------------
   logic [LINES-1:0]   bank_en;
   logic [BASIC_W-1:0] basic_en;
   logic [LINES-1:0]   bank_act;
   logic [BASIC_W-1:0] basic_act;
   logic [NUM_BANKS-1:0] bank_sum;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_en_group #(.W(BANK_W)) u_en (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (wr_stb & hit(bus_addr, bank_ofs(OFS_SET_BASE, b))),
         .clr_we (wr_stb & hit(bus_addr, bank_ofs(OFS_CLR_BASE, b))),
         .wbits  (bus_wdata[BANK_W-1:0]),
         .en     (bank_en[b*BANK_W +: BANK_W])
      );
      assign bank_sum[b] = |bank_act[b*BANK_W +: BANK_W];
   end

   irq_en_group #(.W(BASIC_W)) u_basic_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_stb & hit(bus_addr, OFS_BASIC_SET)),
      .clr_we (wr_stb & hit(bus_addr, OFS_BASIC_CLR)),
      .wbits  (bus_wdata[BASIC_W-1:0]),
      .en     (basic_en)
   );

   assign bank_act  = bank_irq & bank_en;
   assign basic_act = basic_irq & basic_en;

   // ---------------- request encoding ----------------
   logic                bank_found, basic_found;
   logic [BANK_IW-1:0]  bank_idx;
   logic [BASIC_IW-1:0] basic_idx;

   irq_first_set #(.W(LINES)) u_bank_enc (
      .vec (bank_act), .found (bank_found), .idx (bank_idx)
   );
   irq_first_set #(.W(BASIC_W)) u_basic_enc (
      .vec (basic_act), .found (basic_found), .idx (basic_idx)
   );

   always_comb begin
      if (basic_act[0]) begin
         req_index = '0;
      end else if (bank_found) begin
         req_index = {1'b1, bank_idx};
      end else begin
         req_index = IDX_W'(basic_idx);
      end
   end
   assign req_valid = bank_found | basic_found;
   assign irq_out   = (|bank_act) | (|basic_act);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFS_BASIC_STAT)) begin
         bus_rdata[BASIC_W-1:0] = basic_irq;
         bus_rdata[SUMMARY_LSB +: NUM_BANKS] = bank_sum;
      end
      if (hit(bus_addr, OFS_BASIC_SET) || hit(bus_addr, OFS_BASIC_CLR)) begin
         bus_rdata[BASIC_W-1:0] = basic_en;
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit(bus_addr, bank_ofs(OFS_LVL_BASE, b))) begin
            bus_rdata[BANK_W-1:0] = bank_irq[b*BANK_W +: BANK_W];
         end
         if (hit(bus_addr, bank_ofs(OFS_SET_BASE, b)) ||
             hit(bus_addr, bank_ofs(OFS_CLR_BASE, b))) begin
            bus_rdata[BANK_W-1:0] = bank_en[b*BANK_W +: BANK_W];
         end
      end
   end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned BASIC_W   = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_W     = 7
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_sel,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [DATA_W-1:0]             bus_wdata,
   input logic [BASIC_W-1:0]            basic_irq,
   input logic [NUM_BANKS*BANK_W-1:0]   bank_en,
   input logic [BASIC_W-1:0]            basic_en,
   input logic                          irq_out,
   input logic                          req_valid,
   input logic [IDX_W-1:0]              req_index
);
   logic wr;
   assign wr = bus_sel & bus_wr;

   logic touch_none;
   always_comb begin
      touch_none = (bus_addr != ADDR_W'(OFS_BASIC_SET)) &&
                   (bus_addr != ADDR_W'(OFS_BASIC_CLR));
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(bank_ofs(OFS_SET_BASE, b)) ||
             bus_addr == ADDR_W'(bank_ofs(OFS_CLR_BASE, b))) touch_none = 1'b0;
      end
   end

   // R1
   no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en == '0 && basic_en == '0) |-> !irq_out);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      // R2
      set_bits_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == ADDR_W'(bank_ofs(OFS_SET_BASE, b))) |=>
         ((bank_en[b*BANK_W +: BANK_W] & $past(bus_wdata[BANK_W-1:0])) ==
           $past(bus_wdata[BANK_W-1:0])));
      // R3
      clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == ADDR_W'(bank_ofs(OFS_CLR_BASE, b))) |=>
         ((bank_en[b*BANK_W +: BANK_W] & $past(bus_wdata[BANK_W-1:0])) == '0));
   end

   // R2
   basic_set_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFS_BASIC_SET)) |=>
      (basic_en == ($past(basic_en) | $past(bus_wdata[BASIC_W-1:0]))));

   // R5 R9
   other_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && touch_none) |=> ($stable(bank_en) && $stable(basic_en)));

   // R8
   valid_tracks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid == irq_out);

   // R8
   timer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (basic_irq[0] && basic_en[0]) |-> (req_valid && req_index == '0));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
   .NUM_BANKS (NUM_BANKS), .BANK_W (BANK_W), .BASIC_W (BASIC_W),
   .ADDR_W (ADDR_W), .DATA_W (DATA_W), .IDX_W (IDX_W)
) u_chk (
   .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
   .bus_addr (bus_addr), .bus_wdata (bus_wdata), .basic_irq (basic_irq),
   .bank_en (bank_en), .basic_en (basic_en), .irq_out (irq_out),
   .req_valid (req_valid), .req_index (req_index)
);

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  basic_irq = '0;
   logic [63:0] bank_irq = '0;
   logic        irq_out, req_valid;
   logic [6:0]  req_index;

   int n_chk = 0, n_fail = 0;
   logic [63:0] m_bank_en = '0;
   logic [7:0]  m_basic_en = '0;

   always #2 clk = ~clk; // 250 MHz

   irq_bank_ctrl i_irq_bank_ctrl (
      .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .basic_irq, .bank_irq, .irq_out, .req_valid, .req_index
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(logic [7:0] a);
      logic [63:0] act = bank_irq & m_bank_en;
      case (a)
         8'h00: return {22'd0, |act[63:32], |act[31:0], basic_irq};
         8'h04: return bank_irq[31:0];
         8'h08: return bank_irq[63:32];
         8'h10, 8'h1C: return m_bank_en[31:0];
         8'h14, 8'h20: return m_bank_en[63:32];
         8'h18, 8'h24: return {24'd0, m_basic_en};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [7:0] exp_req(); // {valid, index}
      logic [63:0] ba = bank_irq & m_bank_en;
      logic [7:0]  sa = basic_irq & m_basic_en;
      if (sa[0]) return 8'h80;
      for (int i = 0; i < 64; i++) if (ba[i]) return {1'b1, 7'(64 + i)};
      for (int k = 1; k < 8; k++) if (sa[k]) return {1'b1, 7'(k)};
      return 8'h00;
   endfunction

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      case (a)
         8'h10: m_bank_en[31:0]  |= d;
         8'h14: m_bank_en[63:32] |= d;
         8'h18: m_basic_en       |= d[7:0];
         8'h1C: m_bank_en[31:0]  &= ~d;
         8'h20: m_bank_en[63:32] &= ~d;
         8'h24: m_basic_en       &= ~d[7:0];
         default: ;
      endcase
   endtask

   task automatic check_all(string tag);
      logic [7:0] addrs [10] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
                                 8'h1C, 8'h20, 8'h24, 8'h0C};
      logic [7:0] e;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         bus_addr = addrs[i];
         #1;
         check(addrs[i] == 8'h00 ? "R6" : addrs[i] == 8'h0C ? "R9" :
               (addrs[i] == 8'h04 || addrs[i] == 8'h08) ? "R5" : "R4",
               $sformatf("%s read %h", tag, addrs[i]), bus_rdata, exp_read(addrs[i]));
      end
      e = exp_req();
      check("R7", {tag, " irq_out"}, 32'(irq_out), 32'(e[7]));
      check("R8", {tag, " req"}, {24'd0, req_valid, req_index}, 32'(e));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      basic_irq = 8'hFF; bank_irq = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state with all lines asserted
      check_all("R1 reset");

      // Directed: timer beats bank line 0
      bus_write(8'h18, 32'h0000_0001);
      bus_write(8'h10, 32'h0000_0001);
      check_all("R8 timer-vs-line0");
      // R3: clear timer enable, line 0 wins -> 64
      bus_write(8'h24, 32'h0000_0001);
      check_all("R3 line0");
      // bank 1 line 31 alone -> 127
      bus_write(8'h1C, 32'hFFFF_FFFF);
      bus_write(8'h14, 32'h8000_0000);
      basic_irq = 8'h08; bank_irq = 64'h8000_0000_0000_0000;
      check_all("R8 line63");
      // basic 3 only
      bank_irq = '0;
      bus_write(8'h18, 32'h0000_0008);
      check_all("R8 basic3");
      // bank line 5 beats basic 3 -> 69
      bus_write(8'h10, 32'h0000_0020);
      bank_irq = 64'h20;
      check_all("R8 line5-vs-basic3");
      // R5 R9: writes to level and unmapped registers ignored
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_write(8'h0C, 32'hFFFF_FFFF);
      bus_write(8'h3C, 32'hFFFF_FFFF);
      check_all("R5 R9 ignored");
      // R2: zero bits keep, ones set
      bus_write(8'h14, 32'h0000_0000);
      check_all("R2 zero-set");

      // Random phase
      for (int it = 0; it < 300; it++) begin
         logic [7:0] ops [8] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h04, 8'h2C};
         bus_write(ops[$urandom_range(0, 7)], $urandom & $urandom);
         basic_irq = 8'($urandom & $urandom);
         bank_irq  = {32'($urandom & $urandom & $urandom), 32'($urandom & $urandom & $urandom)};
         check_all("R2 R3 R7 R8 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule